// File: doc/BRIEF.md
# Ternary Match Rule Classifier

This block classifies a packet header key against a table of ternary rules. Each rule slot stores a value word, a care mask of the same width and an action code. A key presented on the lookup port is compared against every valid slot at once. Where the care mask is zero, that bit position matches any key bit. Where the care mask is one, the key bit has to equal the stored bit. When more than one slot hits, the slot with the lowest index wins, and its index selects the action returned for the packet.

The same array serves longest-prefix forwarding. Software places longer prefixes in lower-numbered slots, so the most specific route takes priority. Slots are loaded or invalidated one at a time through a single write port. A lookup returns hit, winning index and action two clock edges after it is presented: one edge for the parallel compare and priority pick, and one for the action table read. A lookup that matches nothing returns a configurable default action.

Top module: `tcam_classifier`

## Requirements
- R1: A key bit position whose stored care-mask bit is 0 matches regardless of the key bit, so a loaded slot with an all-zero mask hits on every key.
- R2: A key bit position whose stored care-mask bit is 1 matches only when the key bit equals the stored value bit.
- R3: A slot hits only when every one of its KEY_W bit positions matches; a single differing cared bit makes it miss.
- R4: A slot that is invalid never hits. All slots are invalid after reset. A write with `wr_load`=0 invalidates the addressed slot.
- R5: When several slots hit, the result reports the one with the lowest index, together with the action stored for that slot.
- R6: A lookup accepted with `lk_valid`=1 at a rising edge produces `res_valid`=1 exactly two rising edges later, with `res_valid`=0 one edge later. Back-to-back lookups produce back-to-back results.
- R7: A lookup that hits no slot returns `res_hit`=0, `res_idx`=0 and `res_action`=DEFAULT_ACT.
- R8: A write with `wr_load`=1 stores value, mask and action and marks the slot valid. It is visible to a lookup presented on the following cycle, but not to a lookup presented at the same edge as the write.
- R9: While `rst` is high and on the cycle after it, `res_valid` and `res_hit` are 0. When `res_valid` is 0, `res_hit` is 0.
- R10: With prefixes loaded so that longer prefixes sit at lower indices, a key covered by nested prefixes returns the longest one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one slot |
| wr_load | input | 1 | 1 = load value, mask and action and set valid; 0 = invalidate |
| wr_idx | input | IDX_W | Slot addressed by the write |
| wr_value | input | KEY_W | Stored value bits |
| wr_mask | input | KEY_W | Stored care bits (1 = compare, 0 = don't care) |
| wr_action | input | ACT_W | Action code stored with the slot |
| lk_valid | input | 1 | Lookup request |
| lk_key | input | KEY_W | Header key to classify |
| res_valid | output | 1 | Result strobe |
| res_hit | output | 1 | At least one slot matched |
| res_idx | output | IDX_W | Winning slot index (0 on miss) |
| res_action | output | ACT_W | Action of the winner, or DEFAULT_ACT on miss |

## Verification
Every result is due two rising edges after its lookup. A write is due to affect a lookup one edge after the write itself. The bench drives inputs on falling edges. Its behavioural model advances its own two-stage pipeline and rule table on each rising edge. The model reads its action table before it applies the write of that same edge. The bench compares the model with the ports at every falling edge. The directed lookups also check that `res_valid` is still low after one edge and high after the second. The same-cycle write-and-lookup case is sampled on both of those following falling edges, so the stale result and the fresh result are each checked.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

    // Write operation selected by the wr_load pin
    typedef enum logic {
        OP_INVALIDATE = 1'b0,
        OP_LOAD       = 1'b1
    } wr_op_e;

    // Default sizing of the classifier
    localparam int DEF_ENTRIES = 16;
    localparam int DEF_KEY_W   = 32;
    localparam int DEF_ACT_W   = 8;

    // Index width that never collapses to zero bits
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tcam_entry_array.sv
module tcam_entry_array
    import tcam_pkg::*;
#(
    parameter int N     = DEF_ENTRIES,
    parameter int KEY_W = DEF_KEY_W,
    localparam int IDX_W = idx_width(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  wr_op_e           wr_op,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_value,
    input  logic [KEY_W-1:0] wr_mask,
    input  logic [KEY_W-1:0] key,
    output logic [N-1:0]     hit_vec,
    output logic [N-1:0]     valid_vec
);

    for (genvar e = 0; e < N; e++) begin : g_slot
        logic [KEY_W-1:0] val_q;
        logic [KEY_W-1:0] care_q;
        logic             vld_q;
        logic             sel;

        assign sel = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                vld_q  <= 1'b0;
                val_q  <= '0;
                care_q <= '0;
            end else if (sel) begin
                vld_q <= (wr_op == OP_LOAD);
                if (wr_op == OP_LOAD) begin
                    val_q  <= wr_value;
                    care_q <= wr_mask;
                end
            end
        end

        // A bit mismatches only where it is cared for and differs
        assign hit_vec[e]   = vld_q && (((key ^ val_q) & care_q) == '0);
        assign valid_vec[e] = vld_q;
    end

endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc
    import tcam_pkg::*;
#(
    parameter int N = DEF_ENTRIES,
    localparam int IDX_W = idx_width(N)
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Scan from the top so the lowest set bit is the last assignment
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/tcam_action_ram.sv
module tcam_action_ram
    import tcam_pkg::*;
#(
    parameter int N     = DEF_ENTRIES,
    parameter int ACT_W = DEF_ACT_W,
    localparam int IDX_W = idx_width(N)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ACT_W-1:0] wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ACT_W-1:0] rd_data
);

    logic [ACT_W-1:0] mem_q [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) mem_q[i] <= '0;
        end else if (wr_en) begin
            mem_q[wr_idx] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/tcam_classifier.sv
module tcam_classifier
    import tcam_pkg::*;
#(
    parameter int               NUM_ENTRIES = DEF_ENTRIES,
    parameter int               KEY_W       = DEF_KEY_W,
    parameter int               ACT_W       = DEF_ACT_W,
    parameter logic [ACT_W-1:0] DEFAULT_ACT = '1,
    localparam int              IDX_W       = idx_width(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_load,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [KEY_W-1:0] wr_value,
    input  logic [KEY_W-1:0] wr_mask,
    input  logic [ACT_W-1:0] wr_action,
    input  logic             lk_valid,
    input  logic [KEY_W-1:0] lk_key,
    output logic             res_valid,
    output logic             res_hit,
    output logic [IDX_W-1:0] res_idx,
    output logic [ACT_W-1:0] res_action
);

    wr_op_e                 wr_op;
    logic [NUM_ENTRIES-1:0] hit_vec;
    logic [NUM_ENTRIES-1:0] ent_valid;
    logic                   any_hit;
    logic [IDX_W-1:0]       win_idx;
    logic [ACT_W-1:0]       act_rd;

    // Stage 1 registers: compare and priority pick
    logic                   s1_valid;
    logic                   s1_hit;
    logic [IDX_W-1:0]       s1_idx;

    assign wr_op = wr_load ? OP_LOAD : OP_INVALIDATE;

    tcam_entry_array #(.N(NUM_ENTRIES), .KEY_W(KEY_W)) u_array (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_op     (wr_op),
        .wr_idx    (wr_idx),
        .wr_value  (wr_value),
        .wr_mask   (wr_mask),
        .key       (lk_key),
        .hit_vec   (hit_vec),
        .valid_vec (ent_valid)
    );

    tcam_prio_enc #(.N(NUM_ENTRIES)) u_prio (
        .req (hit_vec),
        .any (any_hit),
        .idx (win_idx)
    );

    tcam_action_ram #(.N(NUM_ENTRIES), .ACT_W(ACT_W)) u_actions (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en && (wr_op == OP_LOAD)),
        .wr_idx  (wr_idx),
        .wr_data (wr_action),
        .rd_idx  (s1_idx),
        .rd_data (act_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_valid <= 1'b0;
            s1_hit   <= 1'b0;
            s1_idx   <= '0;
        end else begin
            s1_valid <= lk_valid;
            s1_hit   <= lk_valid && any_hit;
            s1_idx   <= (lk_valid && any_hit) ? win_idx : '0;
        end
    end

    // Stage 2 registers: action read and result
    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_hit    <= 1'b0;
            res_idx    <= '0;
            res_action <= DEFAULT_ACT;
        end else begin
            res_valid  <= s1_valid;
            res_hit    <= s1_hit;
            res_idx    <= s1_idx;
            res_action <= s1_hit ? act_rd : DEFAULT_ACT;
        end
    end

endmodule

// File: rtl/tcam_classifier_chk.sv
module tcam_classifier_chk
    import tcam_pkg::*;
#(
    parameter int               NUM_ENTRIES = DEF_ENTRIES,
    parameter int               ACT_W       = DEF_ACT_W,
    parameter logic [ACT_W-1:0] DEFAULT_ACT = '1,
    localparam int              IDX_W       = idx_width(NUM_ENTRIES)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   wr_en,
    input logic                   wr_load,
    input logic [IDX_W-1:0]       wr_idx,
    input logic                   lk_valid,
    input logic                   res_valid,
    input logic                   res_hit,
    input logic [IDX_W-1:0]       res_idx,
    input logic [ACT_W-1:0]       res_action,
    input logic [NUM_ENTRIES-1:0] hit_vec,
    input logic [NUM_ENTRIES-1:0] ent_valid,
    input logic                   s1_valid,
    input logic                   s1_hit,
    input logic [IDX_W-1:0]       s1_idx
);

    logic [NUM_ENTRIES-1:0] hv_q;
    logic [NUM_ENTRIES-1:0] below_win;

    always_ff @(posedge clk) hv_q <= hit_vec;
    assign below_win = (NUM_ENTRIES'(1) << s1_idx) - NUM_ENTRIES'(1);

    assert_lookup_latency_R6: assert property (@(posedge clk) disable iff (rst)
        lk_valid |=> ##1 res_valid);
    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (rst)
        !lk_valid |=> ##1 !res_valid);
    assert_miss_default_R7: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_hit) |-> (res_action == DEFAULT_ACT && res_idx == '0));
    assert_idle_no_hit_R9: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !res_hit);
    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (!res_valid && !res_hit));
    assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (rst)
        s1_hit |-> (hv_q[s1_idx] && ((hv_q & below_win) == '0)));
    assert_miss_means_none_R3: assert property (@(posedge clk) disable iff (rst)
        (s1_valid && !s1_hit) |-> (hv_q == '0));
    assert_invalid_never_hits_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_load) |=> !ent_valid[$past(wr_idx)]);
    assert_load_sets_valid_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_load) |=> ent_valid[$past(wr_idx)]);

endmodule

bind tcam_classifier tcam_classifier_chk #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .ACT_W       (ACT_W),
    .DEFAULT_ACT (DEFAULT_ACT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_load    (wr_load),
    .wr_idx     (wr_idx),
    .lk_valid   (lk_valid),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_idx    (res_idx),
    .res_action (res_action),
    .hit_vec    (hit_vec),
    .ent_valid  (ent_valid),
    .s1_valid   (s1_valid),
    .s1_hit     (s1_hit),
    .s1_idx     (s1_idx)
);

// File: tb/tcam_classifier_bench.sv
module tcam_classifier_bench;

    localparam int        CLK_PERIOD = 10;
    localparam int        N     = 16;
    localparam int        KW    = 32;
    localparam int        AW    = 8;
    localparam int        IW    = 4;
    localparam logic [7:0] DEF  = 8'hFF;
    localparam int        LIMIT = 200000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          wr_load = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [KW-1:0] wr_value = '0;
    logic [KW-1:0] wr_mask = '0;
    logic [AW-1:0] wr_action = '0;
    logic          lk_valid = 1'b0;
    logic [KW-1:0] lk_key = '0;
    logic          res_valid;
    logic          res_hit;
    logic [IW-1:0] res_idx;
    logic [AW-1:0] res_action;

    int nchecks = 0;
    int nfail   = 0;
    int cycles  = 0;
    string phase = "R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    tcam_classifier #(.NUM_ENTRIES(N), .KEY_W(KW), .ACT_W(AW), .DEFAULT_ACT(DEF)) u_tcam_classifier (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_load(wr_load), .wr_idx(wr_idx),
        .wr_value(wr_value), .wr_mask(wr_mask), .wr_action(wr_action),
        .lk_valid(lk_valid), .lk_key(lk_key), .res_valid(res_valid), .res_hit(res_hit),
        .res_idx(res_idx), .res_action(res_action)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        nchecks++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [KW-1:0] m_val [N];
    logic [KW-1:0] m_msk [N];
    logic [AW-1:0] m_act [N];
    bit            m_vld [N];
    bit            p_valid, p_hit, e_valid, e_hit;
    int            p_idx, e_idx;
    logic [AW-1:0] e_act;
    bit            found;
    int            widx;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                m_vld[i] <= 0; m_val[i] <= '0; m_msk[i] <= '0; m_act[i] <= '0;
            end
            p_valid <= 0; p_hit <= 0; p_idx <= 0;
            e_valid <= 0; e_hit <= 0; e_idx <= 0; e_act <= DEF;
        end else begin
            e_valid <= p_valid;
            e_hit   <= p_hit;
            e_idx   <= p_idx;
            e_act   <= p_hit ? m_act[p_idx] : DEF;
            found = 0;
            widx  = 0;
            for (int i = 0; i < N; i++) begin
                if (!found && m_vld[i] && (((lk_key ^ m_val[i]) & m_msk[i]) == '0)) begin
                    found = 1;
                    widx  = i;
                end
            end
            p_valid <= lk_valid;
            p_hit   <= lk_valid && found;
            p_idx   <= (lk_valid && found) ? widx : 0;
            if (wr_en) begin
                m_vld[wr_idx] <= wr_load;
                if (wr_load) begin
                    m_val[wr_idx] <= wr_value;
                    m_msk[wr_idx] <= wr_mask;
                    m_act[wr_idx] <= wr_action;
                end
            end
        end
    end

    // Compare with the model on every cycle, away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            check(phase, "res_valid vs model", 32'(res_valid), 32'(e_valid));
            if (e_valid) begin
                check(phase, "res_hit vs model", 32'(res_hit), 32'(e_hit));
                check(phase, "res_idx vs model", 32'(res_idx), 32'(e_idx));
                check(phase, "res_action vs model", 32'(res_action), 32'(e_act));
            end
        end
    end

    task automatic write_slot(input int idx, input bit load, input logic [31:0] v,
                              input logic [31:0] m, input logic [7:0] a);
        @(negedge clk);
        wr_en = 1; wr_load = load; wr_idx = IW'(idx); wr_value = v; wr_mask = m; wr_action = a;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic lookup(input logic [31:0] key, input bit xh, input int xi,
                          input logic [7:0] xa, input string req);
        @(negedge clk);
        lk_valid = 1; lk_key = key;
        @(negedge clk);
        lk_valid = 0;
        check("R6", "res_valid one edge after lookup", 32'(res_valid), 32'd0);
        @(negedge clk);
        check("R6", "res_valid two edges after lookup", 32'(res_valid), 32'd1);
        check(req, "res_hit", 32'(res_hit), 32'(xh));
        check(req, "res_idx", 32'(res_idx), 32'(xi));
        check(req, "res_action", 32'(res_action), 32'(xa));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9", "res_valid in reset", 32'(res_valid), 32'd0);
        check("R9", "res_hit in reset", 32'(res_hit), 32'd0);
        rst = 0;
        @(negedge clk);
        check("R9", "res_valid after reset", 32'(res_valid), 32'd0);

        // Empty table: every slot invalid, so the result is a miss with the default
        phase = "R4";
        lookup(32'h12345678, 0, 0, DEF, "R4");
        phase = "R7";
        lookup(32'h00000000, 0, 0, DEF, "R7");

        // All don't-care slot matches anything
        phase = "R1";
        write_slot(5, 1, 32'hDEADBEEF, 32'h0, 8'h55);
        lookup(32'h00000000, 1, 5, 8'h55, "R1");
        lookup(32'hFFFFFFFF, 1, 5, 8'h55, "R1");

        // Cared bits must be equal; the lower index wins over slot 5
        phase = "R2";
        write_slot(2, 1, 32'hC0A80000, 32'hFFFF0000, 8'h22);
        lookup(32'hC0A81234, 1, 2, 8'h22, "R5");
        lookup(32'hC0A91234, 1, 5, 8'h55, "R3");
        lookup(32'h40A81234, 1, 5, 8'h55, "R2");

        // Longest-prefix ordering
        phase = "R10";
        write_slot(1, 1, 32'hC0A81200, 32'hFFFFFF00, 8'h11);
        lookup(32'hC0A812AB, 1, 1, 8'h11, "R10");
        lookup(32'hC0A8FF00, 1, 2, 8'h22, "R10");

        // Invalidate removes slots from matching
        phase = "R4";
        write_slot(5, 0, 32'h0, 32'h0, 8'h00);
        lookup(32'h01020304, 0, 0, DEF, "R4");
        write_slot(1, 0, 32'h0, 32'h0, 8'h00);
        lookup(32'hC0A812AB, 1, 2, 8'h22, "R4");

        // Write and lookup at the same edge, then the next cycle
        phase = "R8";
        @(negedge clk);
        wr_en = 1; wr_load = 1; wr_idx = 4'd0; wr_value = 32'h0A000000;
        wr_mask = 32'hFF000000; wr_action = 8'h0A;
        lk_valid = 1; lk_key = 32'h0A000001;
        @(negedge clk);
        wr_en = 0;
        @(negedge clk);
        lk_valid = 0;
        check("R8", "same-edge lookup misses", 32'(res_hit), 32'd0);
        check("R8", "same-edge lookup default", 32'(res_action), 32'(DEF));
        @(negedge clk);
        check("R8", "next-cycle lookup hits", 32'(res_hit), 32'd1);
        check("R8", "next-cycle lookup index", 32'(res_idx), 32'd0);
        check("R8", "next-cycle lookup action", 32'(res_action), 32'h0A);

        // Back-to-back mixed traffic against the model
        phase = "R3";
        for (int c = 0; c < 400; c++) begin
            @(negedge clk);
            wr_en = ($urandom_range(0, 3) == 0);
            wr_load = ($urandom_range(0, 4) != 0);
            wr_idx = IW'($urandom_range(0, N - 1));
            wr_value = $urandom;
            wr_mask = ~(32'hFFFFFFFF >> $urandom_range(0, 32));
            wr_action = 8'($urandom);
            lk_valid = ($urandom_range(0, 3) != 0);
            lk_key = m_val[$urandom_range(0, N - 1)] ^ (32'h1 << $urandom_range(0, 31)) &
                     (($urandom_range(0, 1) != 0) ? 32'hFFFFFFFF : 32'h0);
        end
        @(negedge clk);
        wr_en = 0; lk_valid = 0;
        repeat (4) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > LIMIT) begin
            nchecks++;
            nfail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", nchecks, nfail);
            $finish;
        end
    end

endmodule